// File: doc/BRIEF.md
# Load-Use Interlock Detector

This block sits beside the decode stage of a simple in-order integer pipeline in which a memory load delivers its result one slot late. Each cycle it looks at the instruction being offered by decode: what kind of load it is (if it is a load), the register it writes, the register fields it reads and its encoding format. When a load is accepted, its destination is remembered for exactly one instruction slot. If the instruction in that slot reads the remembered register, the block asserts a one-cycle stall and holds decode back. A double-precision load remembers an even/odd register pair. The block does not handle forwarding, memory access or floating-point unit hazards.

Decode talks to the block through a valid/ready handshake. An instruction is accepted on a rising edge where `dec_valid` and `dec_ready` are both high. `dec_ready` is low only during a stall cycle. While `dec_ready` is low, decode must hold the same instruction and keep `dec_valid` high. Because the block holds no data of its own, the handshake creates no other back-pressure. The block also keeps a saturating count of stall events, which a separate clear input empties. It also runs a cycle counter that gains an extra count on each stall cycle, because long-latency units keep running while decode is held.

Register identifiers are `REG_W` bits wide. The top bit selects the file (0 = integer, 1 = floating point) and the lower bits give the index. Integer register 0 is the all-zero identifier.

Top module: `load_use_interlock`

## Requirements
- R1: When a load is accepted and the next valid instruction reads its armed destination, `stall` is 1 and `dec_ready` is 0 for one cycle. In the following cycle that instruction is accepted with no stall.
- R2: Seven operation codes arm the interlock: 2 (byte), 3 (unsigned byte), 4 (halfword), 5 (unsigned halfword), 6 (word), 7 (single float) and 8 (double float). Code 0, codes 9 to 15 and code 1 are not loads.
- R3: The load-high-immediate code 1 never arms the interlock, so an instruction that reads its destination right after it does not stall.
- R4: A double load (code 8) arms both registers of the pair that shares the destination's upper identifier bits, with bit 0 equal to 0 and to 1. A read of either one stalls.
- R5: The format code selects which fields are compared. 0 (register) compares both sources. 1 (immediate) compares source 1 only. 2 (store) compares source 1 and the stored-data field in source 2. 3 (jump) compares none.
- R6: A read of integer register 0 never stalls, and a load whose destination is integer register 0 arms nothing.
- R7: The armed state lasts one instruction slot. An instruction two slots after a load never stalls on it, and `stall` is never high in two consecutive cycles.
- R8: `stall_count` rises by one on every stall cycle and saturates at 2^CNT_W-1.
- R9: `stat_clr` sets `stall_count` to 0 on the next edge and takes priority over an increment in the same cycle.
- R10: `cycle_count` rises by 1 on every clock edge out of reset, and by 2 on an edge that ends a stall cycle.
- R11: After reset, `stall` is 0, `dec_ready` is 1 and both counters are 0.
- R12: With `dec_valid` low, `stall` is 0 whatever the register fields hold. An empty slot also uses up the armed state, so a read after the empty slot does not stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_clr | input | 1 | Clears the stall counter |
| dec_valid | input | 1 | Decode offers an instruction |
| dec_ready | output | 1 | Instruction accepted this cycle (low only when stalling) |
| dec_op | input | 4 | Operation code: load kind or other |
| dec_fmt | input | 2 | Encoding format code |
| dec_dst | input | REG_W | Destination register identifier |
| dec_src1 | input | REG_W | First source register identifier |
| dec_src2 | input | REG_W | Second source or stored-data register identifier |
| stall | output | 1 | Load-use interlock stall this cycle |
| stall_count | output | CNT_W | Saturating count of stall cycles |
| cycle_count | output | CYC_W | Cycle counter including extra stall counts |

## Verification
A stuck or wrongly loaded armed register shows up at once on `stall`. It causes either a missing stall in the slot right after a load, or a stall in a slot that should pass. Either way, the error appears in the same cycle as the dependent instruction. Armed state that outlives its slot shows up as a stall two slots after a load, or as a second stall in a row. The counters drift away from the bench's running totals at the first edge after the fault, and the bench compares them every cycle.

// File: rtl/lui_pkg.sv
`timescale 1ns/1ps
package lui_pkg;

  // Armed destination slots: one normal, one for the odd half of a pair.
  localparam int ARM_SLOTS = 2;

  typedef enum logic [3:0] {
    OP_OTHER = 4'd0,
    OP_LHI   = 4'd1,
    OP_LB    = 4'd2,
    OP_LBU   = 4'd3,
    OP_LH    = 4'd4,
    OP_LHU   = 4'd5,
    OP_LW    = 4'd6,
    OP_LF    = 4'd7,
    OP_LD    = 4'd8
  } op_e;

  typedef enum logic [1:0] {
    FMT_REG   = 2'd0,
    FMT_IMM   = 2'd1,
    FMT_STORE = 2'd2,
    FMT_JUMP  = 2'd3
  } fmt_e;

  // True for loads that read memory (and so have the one-slot delay).
  function automatic logic op_arms(input logic [3:0] op);
    case (op_e'(op))
      OP_LB, OP_LBU, OP_LH, OP_LHU, OP_LW, OP_LF, OP_LD: op_arms = 1'b1;
      default:                                           op_arms = 1'b0;
    endcase
  endfunction

  function automatic logic op_pair(input logic [3:0] op);
    op_pair = (op_e'(op) == OP_LD);
  endfunction

  function automatic logic fmt_uses_src1(input logic [1:0] fmt);
    fmt_uses_src1 = (fmt_e'(fmt) != FMT_JUMP);
  endfunction

  function automatic logic fmt_uses_src2(input logic [1:0] fmt);
    fmt_uses_src2 = (fmt_e'(fmt) == FMT_REG) || (fmt_e'(fmt) == FMT_STORE);
  endfunction

endpackage

// File: rtl/ilk_arm.sv
`timescale 1ns/1ps
module ilk_arm
  import lui_pkg::*;
#(
  parameter int REG_W = 6,
  parameter int SLOTS = ARM_SLOTS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fire,
  input  logic [3:0]                  op,
  input  logic [REG_W-1:0]            dst,
  output logic [SLOTS-1:0]            arm_vld,
  output logic [SLOTS-1:0][REG_W-1:0] arm_id
);

  logic is_ld;
  logic is_pair;

  assign is_ld   = fire && op_arms(op);
  assign is_pair = op_pair(op);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [REG_W-1:0] id_nxt;
    logic             vld_nxt;

    // Slot 0 carries the plain destination, or the even half of a pair;
    // further slots carry the odd half and exist only for pair loads.
    if (s == 0) begin : g_first
      assign id_nxt  = is_pair ? {dst[REG_W-1:1], 1'b0} : dst;
      assign vld_nxt = is_ld && (id_nxt != '0);
    end else begin : g_pair
      assign id_nxt  = {dst[REG_W-1:1], 1'b1};
      assign vld_nxt = is_ld && is_pair && (id_nxt != '0);
    end

    // Armed state is rewritten every cycle, so it lives one slot only.
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        arm_vld[s] <= 1'b0;
        arm_id[s]  <= '0;
      end else begin
        arm_vld[s] <= vld_nxt;
        arm_id[s]  <= id_nxt;
      end
    end
  end

  // R2/R3: anything armed came from a memory load accepted one cycle earlier
  assert_arm_from_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|arm_vld) |-> $past(fire && op_arms(op)));

  // R6: integer register 0 is never armed
  assert_no_zero_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arm_vld[0] |-> (arm_id[0] != '0));

endmodule

// File: rtl/ilk_match.sv
`timescale 1ns/1ps
module ilk_match
  import lui_pkg::*;
#(
  parameter int REG_W = 6,
  parameter int SLOTS = ARM_SLOTS
) (
  input  logic [SLOTS-1:0]            arm_vld,
  input  logic [SLOTS-1:0][REG_W-1:0] arm_id,
  input  logic                        valid,
  input  logic [1:0]                  fmt,
  input  logic [REG_W-1:0]            src1,
  input  logic [REG_W-1:0]            src2,
  output logic                        hazard
);

  logic             chk1;
  logic             chk2;
  logic [SLOTS-1:0] hit;

  // A read of integer register 0 is never a dependency.
  assign chk1 = fmt_uses_src1(fmt) && (src1 != '0);
  assign chk2 = fmt_uses_src2(fmt) && (src2 != '0);

  for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
    assign hit[s] = arm_vld[s] &&
                    ((chk1 && (src1 == arm_id[s])) ||
                     (chk2 && (src2 == arm_id[s])));
  end

  assign hazard = valid && (|hit);

endmodule

// File: rtl/ilk_stats.sv
`timescale 1ns/1ps
module ilk_stats #(
  parameter int CNT_W = 8,
  parameter int CYC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             clr,
  output logic [CNT_W-1:0] stall_count,
  output logic [CYC_W-1:0] cycle_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CYC_W-1:0] CYC_ONE = CYC_W'(1);
  localparam logic [CYC_W-1:0] CYC_TWO = CYC_W'(2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_count <= '0;
      cycle_count <= '0;
    end else begin
      cycle_count <= cycle_count + (stall ? CYC_TWO : CYC_ONE);
      if (clr) begin
        stall_count <= '0;
      end else if (stall && (stall_count != CNT_MAX)) begin
        stall_count <= stall_count + CNT_W'(1);
      end
    end
  end

  assert_cnt_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !clr && (stall_count != CNT_MAX)) |=>
      (stall_count == $past(stall_count) + CNT_W'(1)));

  assert_cnt_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (stall_count == CNT_MAX)) |=> (stall_count == CNT_MAX));

  assert_cnt_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (stall_count == '0));

  assert_cyc_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (cycle_count == $past(cycle_count) + CYC_TWO));

  assert_cyc_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (cycle_count == $past(cycle_count) + CYC_ONE));

endmodule

// File: rtl/load_use_interlock.sv
`timescale 1ns/1ps
module load_use_interlock
  import lui_pkg::*;
#(
  parameter int REG_W = 6,
  parameter int CNT_W = 8,
  parameter int CYC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stat_clr,
  input  logic             dec_valid,
  output logic             dec_ready,
  input  logic [3:0]       dec_op,
  input  logic [1:0]       dec_fmt,
  input  logic [REG_W-1:0] dec_dst,
  input  logic [REG_W-1:0] dec_src1,
  input  logic [REG_W-1:0] dec_src2,
  output logic             stall,
  output logic [CNT_W-1:0] stall_count,
  output logic [CYC_W-1:0] cycle_count
);

  localparam int SLOTS = ARM_SLOTS;

  logic                        fire;
  logic [SLOTS-1:0]            arm_vld;
  logic [SLOTS-1:0][REG_W-1:0] arm_id;
  logic                        hazard;

  assign stall     = hazard;
  assign dec_ready = !hazard;
  assign fire      = dec_valid && !hazard;

  ilk_arm #(.REG_W(REG_W), .SLOTS(SLOTS)) u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .op      (dec_op),
    .dst     (dec_dst),
    .arm_vld (arm_vld),
    .arm_id  (arm_id)
  );

  ilk_match #(.REG_W(REG_W), .SLOTS(SLOTS)) u_match (
    .arm_vld (arm_vld),
    .arm_id  (arm_id),
    .valid   (dec_valid),
    .fmt     (dec_fmt),
    .src1    (dec_src1),
    .src2    (dec_src2),
    .hazard  (hazard)
  );

  ilk_stats #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_stats (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall       (hazard),
    .clr         (stat_clr),
    .stall_count (stall_count),
    .cycle_count (cycle_count)
  );

  // R1: a stall only follows an accepted instruction in the slot before
  assert_stall_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> $past(fire));

  // R7: never two stall cycles in a row
  assert_single_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R12: an empty slot never stalls
  assert_idle_no_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !stall);

endmodule

// File: tb/load_use_interlock_tb.sv
`timescale 1ns/1ps
module load_use_interlock_tb;

  localparam int RW     = 6;
  localparam int CW     = 8;
  localparam int YW     = 32;
  localparam int SATMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stat_clr = 1'b0;
  logic          dec_valid = 1'b0;
  logic [3:0]    dec_op = '0;
  logic [1:0]    dec_fmt = '0;
  logic [RW-1:0] dec_dst = '0;
  logic [RW-1:0] dec_src1 = '0;
  logic [RW-1:0] dec_src2 = '0;
  logic          dec_ready;
  logic          stall;
  logic [CW-1:0] stall_count;
  logic [YW-1:0] cycle_count;

  load_use_interlock #(.REG_W(RW), .CNT_W(CW), .CYC_W(YW)) u_dut (
    .clk(clk), .rst_n(rst_n), .stat_clr(stat_clr),
    .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_op(dec_op), .dec_fmt(dec_fmt), .dec_dst(dec_dst),
    .dec_src1(dec_src1), .dec_src2(dec_src2),
    .stall(stall), .stall_count(stall_count), .cycle_count(cycle_count)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model
  bit          m_av [2];
  logic [RW-1:0] m_aid [2];
  int          m_cnt = 0;
  int unsigned m_cyc = 0;

  localparam logic [3:0] LHI = 4'd1, LB = 4'd2, LW = 4'd6, LD = 4'd8, OTH = 4'd0;
  localparam logic [1:0] F_R = 2'd0, F_I = 2'd1, F_S = 2'd2, F_J = 2'd3;
  localparam logic [RW-1:0] FLT = 6'h20;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit is_ld(input logic [3:0] op);
    return (op >= 4'd2) && (op <= 4'd8);
  endfunction

  function automatic bit reads(input logic [1:0] f, input logic [RW-1:0] s1,
                               input logic [RW-1:0] s2, input logic [RW-1:0] id);
    case (f)
      F_R, F_S: return (s1 == id) || (s2 == id);
      F_I:      return (s1 == id);
      default:  return 1'b0;
    endcase
  endfunction

  function automatic bit m_hazard(input logic [1:0] f, input logic [RW-1:0] s1,
                                  input logic [RW-1:0] s2);
    bit h = 1'b0;
    for (int i = 0; i < 2; i++)
      if (m_av[i] && reads(f, s1, s2, m_aid[i])) h = 1'b1;
    return h;
  endfunction

  // One clock: drive at negedge, check before posedge, update model at posedge.
  task automatic cyc(input string tag, input bit v, input logic [3:0] op,
                     input logic [1:0] f, input logic [RW-1:0] d,
                     input logic [RW-1:0] s1, input logic [RW-1:0] s2,
                     input bit clr, output bit st);
    dec_valid = v; dec_op = op; dec_fmt = f; dec_dst = d;
    dec_src1 = s1; dec_src2 = s2; stat_clr = clr;
    #1;
    st = v && m_hazard(f, s1, s2);
    chk({tag, " stall"}, stall, st);
    chk({tag, " ready"}, dec_ready, !st);
    chk("R8 stall_count", stall_count, m_cnt);
    chk("R10 cycle_count", cycle_count, m_cyc);
    @(posedge clk);
    m_cyc = m_cyc + (st ? 2 : 1);
    if (clr) m_cnt = 0;
    else if (st && m_cnt < SATMAX) m_cnt++;
    if (v && !st && is_ld(op)) begin
      m_aid[0] = (op == LD) ? {d[RW-1:1], 1'b0} : d;
      m_aid[1] = {d[RW-1:1], 1'b1};
      m_av[0]  = (m_aid[0] != '0);
      m_av[1]  = (op == LD) && (m_aid[1] != '0);
    end else begin
      m_av[0] = 1'b0;
      m_av[1] = 1'b0;
    end
    @(negedge clk);
  endtask

  // Offer one instruction and hold it until accepted; n = cycles used.
  task automatic issue(input string tag, input logic [3:0] op, input logic [1:0] f,
                       input logic [RW-1:0] d, input logic [RW-1:0] s1,
                       input logic [RW-1:0] s2, output int n);
    bit st;
    n = 0;
    do begin
      cyc(tag, 1'b1, op, f, d, s1, s2, 1'b0, st);
      n++;
    end while (st && n < 4);
  endtask

  task automatic pair_test(input string tag, input logic [3:0] op, input logic [RW-1:0] d,
                           input logic [1:0] f, input logic [RW-1:0] s1,
                           input logic [RW-1:0] s2, input int exp_slots);
    int n;
    issue(tag, op, F_I, d, 6'd1, 6'd0, n);
    issue(tag, OTH, f, 6'd9, s1, s2, n);
    chk({tag, " slots"}, n, exp_slots);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    bit st;
    void'($urandom(32'd4242));
    m_av[0] = 0; m_av[1] = 0; m_aid[0] = '0; m_aid[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R11 reset stall", stall, 0);
    chk("R11 reset ready", dec_ready, 1);
    chk("R11 reset stall_count", stall_count, 0);
    chk("R11 reset cycle_count", cycle_count, 0);

    // R1 basic dependency: load word r5, register op reads r5
    pair_test("R1 lw-dep", LW, 6'd5, F_R, 6'd5, 6'd2, 2);
    pair_test("R1 lw-indep", LW, 6'd5, F_R, 6'd3, 6'd2, 1);

    // R2 every load kind arms
    for (int k = 2; k <= 8; k++) pair_test("R2 kind", 4'(k), 6'd12, F_I, 6'd12, 6'd0, 2);
    pair_test("R2 other-op", 4'd9, 6'd12, F_I, 6'd12, 6'd0, 1);

    // R3 load-high-immediate exempt
    pair_test("R3 lhi", LHI, 6'd6, F_R, 6'd6, 6'd6, 1);

    // R4 double load pair
    pair_test("R4 ld-odd", LD, FLT | 6'd4, F_R, 6'd1, FLT | 6'd5, 2);
    pair_test("R4 ld-even", LD, FLT | 6'd5, F_I, FLT | 6'd4, 6'd0, 2);
    pair_test("R4 ld-next", LD, FLT | 6'd4, F_R, FLT | 6'd6, FLT | 6'd3, 1);
    pair_test("R4 lw-noodd", LW, FLT | 6'd4, F_I, FLT | 6'd5, 6'd0, 1);

    // R5 formats
    pair_test("R5 imm-src2", LW, 6'd7, F_I, 6'd1, 6'd7, 1);
    pair_test("R5 store-data", LW, 6'd7, F_S, 6'd1, 6'd7, 2);
    pair_test("R5 jump", LW, 6'd7, F_J, 6'd7, 6'd7, 1);
    pair_test("R5 reg-src2", LW, 6'd7, F_R, 6'd1, 6'd7, 2);

    // R6 integer r0
    pair_test("R6 dst-r0", LW, 6'd0, F_R, 6'd0, 6'd0, 1);
    pair_test("R6 src-r0", LW, 6'd3, F_R, 6'd0, 6'd0, 1);
    pair_test("R6 ld-r0pair", LD, 6'd0, F_I, 6'd1, 6'd0, 2);

    // R7 armed state lasts one slot
    issue("R7 load", LW, F_I, 6'd8, 6'd1, 6'd0, n);
    issue("R7 gap", OTH, F_I, 6'd9, 6'd2, 6'd0, n);
    issue("R7 late", OTH, F_R, 6'd9, 6'd8, 6'd8, n);
    chk("R7 late slots", n, 1);
    issue("R7 chain1", LW, F_I, 6'd9, 6'd1, 6'd0, n);
    issue("R7 chain2", LW, F_I, 6'd10, 6'd9, 6'd0, n);
    chk("R7 chain2 slots", n, 2);
    issue("R7 chain3", OTH, F_I, 6'd11, 6'd10, 6'd0, n);
    chk("R7 chain3 slots", n, 2);

    // R12 bubble
    issue("R12 load", LW, F_I, 6'd11, 6'd1, 6'd0, n);
    cyc("R12 bubble", 1'b0, OTH, F_R, 6'd0, 6'd11, 6'd11, 1'b0, st);
    chk("R12 bubble stall", st, 0);
    issue("R12 after", OTH, F_R, 6'd9, 6'd11, 6'd11, n);
    chk("R12 after slots", n, 1);

    // R9 clear during a stall cycle wins over the increment
    issue("R9 load", LW, F_I, 6'd13, 6'd1, 6'd0, n);
    cyc("R9 clr", 1'b1, OTH, F_I, 6'd9, 6'd13, 6'd0, 1'b1, st);
    chk("R9 clr-stall", st, 1);
    #1;
    chk("R9 count after clr", stall_count, 0);
    cyc("R9 retry", 1'b1, OTH, F_I, 6'd9, 6'd13, 6'd0, 1'b0, st);

    // R8 saturation
    for (int i = 0; i < SATMAX + 5; i++) pair_test("R8 sat", LB, 6'd14, F_I, 6'd14, 6'd0, 2);
    #1;
    chk("R8 saturated", stall_count, SATMAX);
    cyc("R9 clr2", 1'b0, OTH, F_R, 6'd0, 6'd0, 6'd0, 1'b1, st);
    #1;
    chk("R9 cleared", stall_count, 0);

    // random mix, all checked against the model (R1, R2, R5, R7, R8, R10)
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] op;
      logic [RW-1:0] d, a, b;
      op = 4'($urandom_range(0, 10));
      d  = {1'($urandom_range(0, 1)), 5'($urandom_range(0, 3))};
      a  = {1'($urandom_range(0, 1)), 5'($urandom_range(0, 3))};
      b  = {1'($urandom_range(0, 1)), 5'($urandom_range(0, 3))};
      cyc("R1 random", $urandom_range(0, 7) != 0, op, 2'($urandom_range(0, 3)),
          d, a, b, $urandom_range(0, 63) == 0, st);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule